// File: doc/BRIEF.md
# Multicycle Phase-Sequenced 16-bit Core

This block is a small stored-program processor core with 16-bit words and 16-bit addresses. A single phase register steps every instruction through fixed phases: fetch (three steps), decode, address evaluation, operand fetch, execute and store result. Program counter, instruction register, memory address register, memory data register, eight general registers and a three-function ALU all exchange values over one internal bus. At most one source drives that bus in any cycle, and it does so only while its gate is enabled.

Memory is reached only through the address and data registers, over a read port. The core raises a request and holds it until the memory signals ready, so a read may take any number of cycles. Two instructions are executed: a register/immediate add and a base-plus-offset load. Every other opcode passes through decode and then returns to fetch without effect. A debug select port reads out any general register, and the program counter and phase code are visible as outputs.

Top module: `phase_cpu`

## Requirements
- R1: While reset is low and after it is released, the phase code is 0, PC is 0, all eight general registers read 0 and no memory request is raised.
- R2: In phase 0 (phase codes: 0 fetch-address, 1 fetch-read, 2 load IR, 3 decode, 4 evaluate address, 5 fetch operands, 6 execute, 7 store), MAR takes the value of PC and PC increments by one, both in the same cycle.
- R3: A memory read holds mem_req high with a stable mem_addr (equal to MAR) until the cycle in which mem_ready is high. MDR captures mem_rdata in that cycle, and there may be any number of wait cycles.
- R4: One cycle after the instruction read completes, IR holds the word that was read. Decode then selects the operation from IR[15:12].
- R5: The bus has four gated sources: PC, MDR, ALU output and address adder. No two of them drive the bus in the same cycle, and the ALU output drives it only in the store phase of an add.
- R6: Opcode 0001 is add. The destination is [11:9] and the first source is [8:6]. When bit 5 is 0 the second source is the register in [2:0]; when bit 5 is 1 it is [4:0] sign-extended to 16 bits. The sum wraps modulo 2^16.
- R7: Opcode 0110 is load. The destination is [11:9] and the base register is [8:6]. The address is the base plus [5:0] sign-extended, modulo 2^16, and the destination receives the memory word at that address. The destination may equal the base.
- R8: Every opcode other than 0001 and 0110 leaves all registers unchanged and returns to phase 0 right after decode.
- R9: With zero wait cycles, an add and a load each take 7 cycles and any other opcode takes 4 cycles. Each memory wait cycle adds one cycle.
- R10: After the store phase the core returns to phase 0, and PC changes only in phase 0, so PC already holds the address of the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Read address (MAR) |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Read completes this cycle |
| dbg_sel | input | 3 | General register to read out |
| dbg_reg | output | 16 | Contents of the selected register |
| pc_o | output | 16 | Program counter |
| phase_o | output | 3 | Current phase code |

## Verification
Register results become visible only after the store phase of each instruction. The bench therefore waits until the core is back in phase 0 with PC equal to the program length, and only then reads every register through the debug port. At that point, the number of cycles since reset release must equal the sum of 7, 7 or 4 per instruction plus the wait cycles that the bench's memory model itself inserted. That sum is compared exactly. The per-cycle relations (PC and MAR one cycle after phase 0, MDR in the ready cycle, IR one cycle after phase 2, return to phase 0 one cycle after store) are checked in the cycle right after their cause.

// File: rtl/phase_cpu.sv
module phase_cpu (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ready,
  input  logic [2:0]  dbg_sel,
  output logic [15:0] dbg_reg,
  output logic [15:0] pc_o,
  output logic [2:0]  phase_o
);

  typedef enum logic [2:0] {
    PH_FADR  = 3'd0,
    PH_FRD   = 3'd1,
    PH_FIR   = 3'd2,
    PH_DEC   = 3'd3,
    PH_EVAL  = 3'd4,
    PH_OPND  = 3'd5,
    PH_EXEC  = 3'd6,
    PH_STORE = 3'd7
  } phase_t;

  phase_t      ph, ph_nxt;
  logic [15:0] pc, mar, mdr, ir, opa, opb;
  logic [15:0] rf [8];
  logic [15:0] bus, alu_y, ea, opc_hot, sx5;
  logic [1:0]  aluk;
  logic        g_pc, g_mdr, g_alu, g_ea;
  logic        is_add, is_ld;

  assign opc_hot = 16'h0001 << ir[15:12];
  assign is_add  = opc_hot[1];
  assign is_ld   = opc_hot[6];

  assign sx5 = {{11{ir[4]}}, ir[4:0]};
  assign ea  = rf[ir[8:6]] + {{10{ir[5]}}, ir[5:0]};

  assign aluk = is_add ? 2'b00 : 2'b11;
  always_comb begin
    case (aluk)
      2'b00:   alu_y = opa + opb;
      2'b01:   alu_y = opa & opb;
      2'b10:   alu_y = ~opa;
      default: alu_y = opa;
    endcase
  end

  assign g_pc  = (ph == PH_FADR);
  assign g_mdr = (ph == PH_FIR) || (ph == PH_STORE && is_ld);
  assign g_alu = (ph == PH_STORE) && is_add;
  assign g_ea  = (ph == PH_EVAL);

  assign bus = ({16{g_pc}}  & pc)
             | ({16{g_mdr}} & mdr)
             | ({16{g_alu}} & alu_y)
             | ({16{g_ea}}  & ea);

  assign mem_req  = (ph == PH_FRD) || (ph == PH_OPND && is_ld);
  assign mem_addr = mar;

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_FADR:  ph_nxt = PH_FRD;
      PH_FRD:   if (mem_ready) ph_nxt = PH_FIR;
      PH_FIR:   ph_nxt = PH_DEC;
      PH_DEC:   ph_nxt = is_ld ? PH_EVAL : (is_add ? PH_OPND : PH_FADR);
      PH_EVAL:  ph_nxt = PH_OPND;
      PH_OPND:  if (!is_ld) ph_nxt = PH_EXEC;
                else if (mem_ready) ph_nxt = PH_STORE;
      PH_EXEC:  ph_nxt = PH_STORE;
      PH_STORE: ph_nxt = PH_FADR;
      default:  ph_nxt = PH_FADR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_FADR;
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      opa <= '0;
      opb <= '0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      ph <= ph_nxt;
      case (ph)
        PH_FADR: begin
          mar <= bus;
          pc  <= pc + 16'd1;
        end
        PH_FRD:   if (mem_ready) mdr <= mem_rdata;
        PH_FIR:   ir <= bus;
        PH_EVAL:  mar <= bus;
        PH_OPND: begin
          if (is_ld && mem_ready) mdr <= mem_rdata;
          if (is_add) begin
            opa <= rf[ir[8:6]];
            opb <= ir[5] ? sx5 : rf[ir[2:0]];
          end
        end
        PH_STORE: rf[ir[11:9]] <= bus;
        default: ;
      endcase
    end
  end

  assign dbg_reg = rf[dbg_sel];
  assign pc_o    = pc;
  assign phase_o = ph;

endmodule

// File: rtl/phase_cpu_chk.sv
module phase_cpu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  ph,
  input logic [15:0] pc,
  input logic [15:0] mar,
  input logic [15:0] mdr,
  input logic [15:0] ir,
  input logic        g_pc,
  input logic        g_mdr,
  input logic        g_alu,
  input logic        g_ea,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_rdata,
  input logic        mem_ready
);

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph == 3'd0 |=> pc == $past(pc) + 16'd1 && mar == $past(pc));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  p_mdr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> mdr == $past(mem_rdata));

  p_ir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ph == 3'd2 |=> ir == $past(mdr));

  p_bus_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({g_pc, g_mdr, g_alu, g_ea}));

  p_alu_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    g_alu |-> ph == 3'd7);

  p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ph == 3'd7 |=> ph == 3'd0);

  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ph != 3'd0 |=> $stable(pc));

endmodule

bind phase_cpu phase_cpu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .pc(pc), .mar(mar), .mdr(mdr), .ir(ir),
  .g_pc(g_pc), .g_mdr(g_mdr), .g_alu(g_alu), .g_ea(g_ea),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .mem_ready(mem_ready)
);

// File: tb/phase_cpu_tb.sv
`timescale 1ns/100ps
module phase_cpu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_ready = 1'b0;
  logic [15:0] mem_addr, mem_rdata = '0;
  logic [2:0]  dbg_sel = '0;
  logic [15:0] dbg_reg, pc_o;
  logic [2:0]  phase_o;

  int checks = 0, errors = 0;
  int waits = 0, wcnt = 0;
  int seed;
  logic [15:0] mem [256];
  logic [15:0] xrf [8];
  int xcyc;

  always #2 clk = ~clk;

  phase_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .dbg_sel(dbg_sel),
    .dbg_reg(dbg_reg), .pc_o(pc_o), .phase_o(phase_o)
  );

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt == 0) begin
        mem_ready <= 1'b1;
        mem_rdata <= mem[mem_addr[7:0]];
      end else begin
        wcnt      <= wcnt - 1;
        mem_ready <= 1'b0;
        waits     <= waits + 1;
      end
    end else begin
      mem_ready <= 1'b0;
      wcnt      <= $urandom % 4;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_addi(int dr, int sr, int imm);
    logic [4:0] i5 = imm[4:0];
    return {4'b0001, dr[2:0], sr[2:0], 1'b1, i5};
  endfunction

  function automatic logic [15:0] enc_addr(int dr, int s1, int s2);
    return {4'b0001, dr[2:0], s1[2:0], 3'b000, s2[2:0]};
  endfunction

  function automatic logic [15:0] enc_ld(int dr, int b, int off);
    logic [5:0] o6 = off[5:0];
    return {4'b0110, dr[2:0], b[2:0], o6};
  endfunction

  task automatic model(input int n);
    logic [15:0] w, a;
    for (int r = 0; r < 8; r++) xrf[r] = '0;
    xcyc = 0;
    for (int i = 0; i < n; i++) begin
      w = mem[i];
      if (w[15:12] == 4'b0001) begin
        a = w[5] ? {{11{w[4]}}, w[4:0]} : xrf[w[2:0]];
        xrf[w[11:9]] = xrf[w[8:6]] + a;
        xcyc += 7;
      end else if (w[15:12] == 4'b0110) begin
        a = xrf[w[8:6]] + {{10{w[5]}}, w[5:0]};
        xrf[w[11:9]] = mem[a[7:0]];
        xcyc += 7;
      end else xcyc += 4;
    end
  endtask

  task automatic do_reset(input bit check_it);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    if (check_it) begin
      chk("R1 phase", phase_o, 0);
      chk("R1 pc", pc_o, 0);
      chk("R1 req", mem_req, 0);
      for (int r = 0; r < 8; r++) begin
        dbg_sel = r[2:0]; #0.1;
        chk("R1 reg", dbg_reg, 0);
      end
    end
    rst_n = 1'b1;
    waits = 0;
  endtask

  task automatic run(input int n, input string tag);
    int k = 0;
    model(n);
    do_reset(0);
    do begin
      @(negedge clk);
      k++;
    end while (!(phase_o == 3'd0 && pc_o == n[15:0]) && k < 5000);
    if (k >= 5000) begin
      errors++;
      $display("FAIL %s R10: program did not complete, pc %0h expected %0h", tag, pc_o, n);
    end
    chk({tag, " R9 cycles"}, k, xcyc + waits);
    chk({tag, " R10 pc"}, pc_o, n);
    for (int r = 0; r < 8; r++) begin
      dbg_sel = r[2:0]; #0.1;
      chk({tag, " R6/R7/R8 reg"}, dbg_reg, xrf[r]);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = '0;
    for (int i = 128; i < 256; i++) mem[i] = 16'($urandom);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, op;
    seed = $urandom(32'h5eed_1234);
    clear_mem();
    do_reset(1);
    // R1 also after release, before first edge completes
    chk("R1 phase after release", phase_o, 0);

    // directed program: R6 immediate/register/wrap, R7 offsets and wrap, R8 no-ops
    mem[0]  = enc_addi(1, 0, 7);
    mem[1]  = enc_addi(2, 0, -16);
    mem[2]  = enc_addr(3, 1, 2);
    mem[3]  = enc_addr(3, 3, 3);
    mem[4]  = 16'h5000;
    mem[5]  = enc_addi(4, 0, 15);
    mem[6]  = enc_addr(4, 4, 4);
    mem[7]  = enc_addr(4, 4, 4);
    mem[8]  = enc_addr(4, 4, 4);
    mem[9]  = enc_addi(4, 4, 12);
    mem[10] = enc_ld(5, 4, -4);
    mem[11] = enc_ld(6, 4, 31);
    mem[12] = enc_ld(4, 4, 0);
    mem[13] = 16'hF025;
    mem[14] = 16'hFFFF;
    mem[15] = enc_ld(7, 0, 3);
    mem[16] = enc_addi(0, 0, -1);
    mem[17] = enc_ld(1, 0, 1);
    run(18, "directed");

    // R8/R9: program of only no-ops
    clear_mem();
    for (int i = 0; i < 6; i++) mem[i] = {4'(i + 8), 12'hABC};
    run(6, "nops");

    for (int p = 0; p < 5; p++) begin
      clear_mem();
      n = 30;
      for (int i = 0; i < n; i++) begin
        op = $urandom % 10;
        if (op < 4)      mem[i] = enc_addi($urandom % 8, $urandom % 8, $urandom % 32);
        else if (op < 7) mem[i] = enc_addr($urandom % 8, $urandom % 8, $urandom % 8);
        else if (op < 9) mem[i] = enc_ld($urandom % 8, $urandom % 8, $urandom % 64);
        else begin
          mem[i] = 16'($urandom);
          if (mem[i][15:12] == 4'b0001 || mem[i][15:12] == 4'b0110) mem[i][15:12] = 4'b0000;
        end
      end
      run(n, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule